// File: doc/BRIEF.md
# Beat Interval Meter

This block turns a stream of light-sensor samples into beat-to-beat period measurements. Each accepted sample passes through a cheap two-section IIR band-pass filter (a shift-based high-pass that removes the slowly moving bias, followed by a shift-based low-pass that removes fast noise). With the default shifts and a 31.25 kHz sample rate, the pass band sits around the 0.5 Hz to 5 Hz range where a pulse lives.

A hysteresis comparator watches the filtered value. It declares a rising edge when the value climbs above a programmable threshold and a falling edge when it drops below the negated threshold. Two independent sample counters time rising-to-rising and falling-to-falling intervals. Every completed interval is reported on its own, with no averaging. An interval longer than a programmable limit is flagged as a timeout instead of being reported.

Downstream logic converts the period in samples to a rate. The block only supplies the raw per-beat periods.

Top module: `beat_interval_meter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `per_valid`, `per_rise`, `per_timeout` are 0 and `per_samples` is 0; the comparator state starts "low" and neither polarity is armed.
- R2: Only cycles with `smp_valid`=1 advance the filter. With `xs = smp_data * 2^FRAC_W`, `hp = xs - dc`, the updates are `dc += hp >>> HP_SHIFT` and `lp += (hp - lp) >>> LP_SHIFT`, using arithmetic shifts on signed values and old state on the right-hand side. The filtered value `f` is the updated `lp`.
- R3: On a valid sample with the state low, `f > hyst_thr * 2^FRAC_W` is a rising edge and sets the state high. With the state high, `f < -(hyst_thr * 2^FRAC_W)` is a falling edge and sets the state low. There is no other edge, so rising and falling edges alternate.
- R4: The first edge of each polarity after reset only arms that polarity's timer and produces no report.
- R5: For an armed polarity, the interval is the number of valid samples from the previous same-polarity edge sample to this one. It appears on `per_samples` with `per_valid`=1 for exactly one cycle, the cycle after the edge sample is accepted. `per_rise` is 1 for rising-to-rising and 0 for falling-to-falling. When `per_valid` is 0, `per_samples` is 0.
- R6: Every edge of an armed polarity produces its own report of that single interval, with no averaging between beats, for both polarities.
- R7: An interval greater than `TMO_LIMIT` gives a one-cycle `per_timeout` pulse (with `per_rise` giving the polarity) and no `per_valid`. Timing restarts from that edge, so the next edge of that polarity is measured from it. The interval count saturates at 2^CNT_W-1.
- R8: Cycles with `smp_valid`=0 are ignored: `smp_data` is not sampled, counters do not advance and no report follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Signed input sample |
| hyst_thr | input | DATA_W | Unsigned hysteresis threshold in input units |
| per_valid | output | 1 | One-cycle strobe for a measured period |
| per_rise | output | 1 | 1: rising-to-rising interval, 0: falling-to-falling |
| per_samples | output | CNT_W | Period in samples (0 when no report) |
| per_timeout | output | 1 | One-cycle strobe: interval exceeded `TMO_LIMIT` |

## Verification
The edge that ends an over-long interval does two jobs in the same cycle. It raises the timeout for the old interval, and it also starts the next interval. A correct design must not lose either job. The bench provokes this by holding the input at zero well past the limit and then restarting the square wave. The first edge of each polarity must produce a timeout. The following edge must report a valid period counted from the timed-out edge. A bench model steps the filter, comparator and counters sample by sample and is compared with the outputs on every clock.

// File: rtl/bim_pkg.sv
package bim_pkg;
  localparam int unsigned POL_N    = 2;
  localparam int unsigned FALL_IDX = 0;
  localparam int unsigned RISE_IDX = 1;
endpackage

// File: rtl/bim_bandpass.sv
module bim_bandpass #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned FRAC_W   = 4,
  parameter int unsigned HP_SHIFT = 13,
  parameter int unsigned LP_SHIFT = 10,
  parameter int unsigned ACC_W    = DATA_W + FRAC_W + 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic [DATA_W-1:0]        x,
  output logic signed [ACC_W-1:0]  f_next
);
  localparam int unsigned EXT_W = ACC_W - DATA_W - FRAC_W;

  logic signed [ACC_W-1:0] dc_q, dc_d, lp_q, lp_d, xs, hp, lp_err;

  always_comb begin
    xs     = {{EXT_W{x[DATA_W-1]}}, x, {FRAC_W{1'b0}}};
    hp     = xs - dc_q;
    lp_err = hp - lp_q;
    dc_d   = dc_q;
    lp_d   = lp_q;
    if (tick) begin
      dc_d = dc_q + (hp >>> HP_SHIFT);
      lp_d = lp_q + (lp_err >>> LP_SHIFT);
    end
    f_next = lp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dc_q <= '0;
      lp_q <= '0;
    end else if (tick) begin
      dc_q <= dc_d;
      lp_q <= lp_d;
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(lp_q) && $stable(dc_q)));
endmodule

// File: rtl/bim_edge_detect.sv
module bim_edge_detect #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FRAC_W = 4,
  parameter int unsigned ACC_W  = DATA_W + FRAC_W + 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic signed [ACC_W-1:0]  f,
  input  logic [DATA_W-1:0]        thr,
  output logic                     rise,
  output logic                     fall
);
  localparam int unsigned EXT_W = ACC_W - DATA_W - FRAC_W;

  logic signed [ACC_W-1:0] lim_p, lim_n;
  logic hi_q, hi_d;

  always_comb begin
    lim_p = {{EXT_W{1'b0}}, thr, {FRAC_W{1'b0}}};
    lim_n = -lim_p;
    rise  = tick && !hi_q && (f > lim_p);
    fall  = tick &&  hi_q && (f < lim_n);
    hi_d  = hi_q;
    if (rise) hi_d = 1'b1;
    if (fall) hi_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= 1'b0;
    else if (tick) hi_q <= hi_d;
  end

  p_rise_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> hi_q);
  p_fall_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !hi_q);
endmodule

// File: rtl/bim_interval_timer.sv
module bim_interval_timer #(
  parameter int unsigned CNT_W     = 20,
  parameter int unsigned TMO_LIMIT = 78125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             edge_hit,
  output logic             rep_valid,
  output logic             rep_tmo,
  output logic [CNT_W-1:0] rep_len
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIM     = CNT_W'(TMO_LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, len_q, len_d;
  logic armed_q, armed_d, val_q, val_d, tmo_q, tmo_d;

  always_comb begin
    cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    cnt_d   = cnt_q;
    armed_d = armed_q;
    val_d   = 1'b0;
    tmo_d   = 1'b0;
    len_d   = '0;
    if (tick) begin
      cnt_d = cnt_inc;
      if (edge_hit) begin
        cnt_d   = '0;
        armed_d = 1'b1;
        if (armed_q) begin
          if (cnt_inc > LIM) tmo_d = 1'b1;
          else begin
            val_d = 1'b1;
            len_d = cnt_inc;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      val_q   <= 1'b0;
      tmo_q   <= 1'b0;
      len_q   <= '0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      val_q   <= val_d;
      tmo_q   <= tmo_d;
      len_q   <= len_d;
    end
  end

  assign rep_valid = val_q;
  assign rep_tmo   = tmo_q;
  assign rep_len   = len_q;

  p_first_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && edge_hit && !armed_q) |=> (!val_q && !tmo_q));
  p_len_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    val_q |-> (len_q <= LIM && len_q != '0));
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (!val_q && !tmo_q));
endmodule

// File: rtl/beat_interval_meter.sv
module beat_interval_meter
  import bim_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned FRAC_W    = 4,
  parameter int unsigned HP_SHIFT  = 13,
  parameter int unsigned LP_SHIFT  = 10,
  parameter int unsigned CNT_W     = 20,
  parameter int unsigned TMO_LIMIT = 78125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [DATA_W-1:0] hyst_thr,
  output logic              per_valid,
  output logic              per_rise,
  output logic [CNT_W-1:0]  per_samples,
  output logic              per_timeout
);
  localparam int unsigned ACC_W = DATA_W + FRAC_W + 3;

  logic signed [ACC_W-1:0] filt;
  logic [POL_N-1:0] edge_vec, val_vec, tmo_vec;
  logic [CNT_W-1:0] len_arr [POL_N];

  bim_bandpass #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .HP_SHIFT(HP_SHIFT),
                 .LP_SHIFT(LP_SHIFT), .ACC_W(ACC_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .tick(smp_valid), .x(smp_data), .f_next(filt));

  bim_edge_detect #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .tick(smp_valid), .f(filt), .thr(hyst_thr),
    .rise(edge_vec[RISE_IDX]), .fall(edge_vec[FALL_IDX]));

  for (genvar p = 0; p < POL_N; p++) begin : g_timer
    bim_interval_timer #(.CNT_W(CNT_W), .TMO_LIMIT(TMO_LIMIT)) u_tmr (
      .clk(clk), .rst_n(rst_n), .tick(smp_valid), .edge_hit(edge_vec[p]),
      .rep_valid(val_vec[p]), .rep_tmo(tmo_vec[p]), .rep_len(len_arr[p]));
  end

  always_comb begin
    per_valid   = |val_vec;
    per_timeout = |tmo_vec;
    per_rise    = val_vec[RISE_IDX] | tmo_vec[RISE_IDX];
    per_samples = '0;
    if (val_vec[RISE_IDX])      per_samples = len_arr[RISE_IDX];
    else if (val_vec[FALL_IDX]) per_samples = len_arr[FALL_IDX];
  end

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(per_valid && per_timeout));
  p_one_pol_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(val_vec | tmo_vec));
endmodule

// File: tb/beat_interval_meter_bench.sv
module beat_interval_meter_bench;
  localparam int DW = 16, FW = 4, KH = 5, KL = 2, CW = 20, LIM = 300;

  logic clk = 1'b0;
  logic rst_n, smp_valid;
  logic [DW-1:0] smp_data, hyst_thr;
  logic per_valid, per_rise, per_timeout;
  logic [CW-1:0] per_samples;

  always #10 clk = ~clk;

  beat_interval_meter #(.DATA_W(DW), .FRAC_W(FW), .HP_SHIFT(KH), .LP_SHIFT(KL),
                        .CNT_W(CW), .TMO_LIMIT(LIM)) u_beat_interval_meter (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .hyst_thr(hyst_thr), .per_valid(per_valid), .per_rise(per_rise),
    .per_samples(per_samples), .per_timeout(per_timeout));

  int checks = 0, fails = 0;
  int n_val = 0, n_rise = 0, n_fall = 0, n_tmo = 0, n_ev = 0;
  longint m_dc = 0, m_lp = 0;
  int m_hi = 0;
  longint m_cnt [2] = '{0, 0};
  int m_arm [2] = '{0, 0};
  int e_v = 0, e_r = 0, e_t = 0;
  longint e_len = 0;
  logic in_reset = 1'b1;

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    string tag;
    tag = in_reset ? "R1" : (per_timeout !== 1'(e_t)) ? "R7" :
          (per_valid !== 1'(e_v)) ? "R5" : "R6";
    check(per_valid === 1'(e_v), tag, "per_valid", per_valid, e_v);
    check(per_timeout === 1'(e_t), tag, "per_timeout", per_timeout, e_t);
    check(per_rise === 1'(e_r), tag, "per_rise", per_rise, e_r);
    check(per_samples === CW'(e_len), tag, "per_samples", per_samples, e_len);
    if (per_valid === 1'b1) begin
      n_val++;
      if (per_rise) n_rise++; else n_fall++;
    end
    if (per_timeout === 1'b1) n_tmo++;
    if (per_valid === 1'b1 || per_timeout === 1'b1) n_ev++;
  endtask

  // Model of R2..R8, stepped once per clock with the inputs being driven
  task automatic model(input bit v, input longint x, input longint thr);
    longint hp, d, tp, cinc;
    int ev [2];
    e_v = 0; e_r = 0; e_t = 0; e_len = 0;
    if (!v) return;                    // R8: nothing moves
    hp = x * (1 << FW) - m_dc;
    d  = hp - m_lp;
    m_dc = m_dc + (hp >>> KH);
    m_lp = m_lp + (d >>> KL);
    tp = thr * (1 << FW);
    ev[1] = (m_hi == 0 && m_lp > tp) ? 1 : 0;
    ev[0] = (m_hi == 1 && m_lp < -tp) ? 1 : 0;
    if (ev[1] != 0) m_hi = 1;
    if (ev[0] != 0) m_hi = 0;
    for (int p = 0; p < 2; p++) begin
      cinc = (m_cnt[p] == (longint'(1) << CW) - 1) ? m_cnt[p] : m_cnt[p] + 1;
      if (ev[p] != 0) begin
        if (m_arm[p] != 0) begin
          e_r = p;
          if (cinc > LIM) e_t = 1;
          else begin e_v = 1; e_len = cinc; end
        end
        m_arm[p] = 1;
        m_cnt[p] = 0;
      end else m_cnt[p] = cinc;
    end
  endtask

  task automatic step(input bit v, input longint x);
    @(negedge clk);
    compare();
    smp_valid = v;
    smp_data  = DW'(x);
    model(v, x, longint'(hyst_thr));
  endtask

  task automatic square(input int period, input int beats, input int amp,
                        input int gap);
    for (int b = 0; b < beats; b++)
      for (int s = 0; s < period; s++) begin
        for (int g = 1; g < gap; g++) step(1'b0, 12345); // R8 junk when idle
        step(1'b1, (s < period / 2) ? amp : -amp);
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; hyst_thr = DW'(200);
    repeat (4) begin
      @(negedge clk);
      compare();                       // R1 during reset
    end
    check(per_valid === 1'b0 && per_timeout === 1'b0 && per_samples === '0,
          "R1", "reset outputs", per_valid, 0);
    rst_n = 1'b1;
    in_reset = 1'b0;

    // R4/R5: steady beat; first edges only arm
    base = n_val;
    square(60, 10, 2000, 1);
    check(n_val - base >= 12, "R5", "periods reported", n_val - base, 12);
    check(n_rise > 0 && n_fall > 0, "R6", "both polarities", n_rise, n_fall);

    // R6: changing beat lengths, each reported alone
    base = n_val;
    square(40, 4, 2000, 1);
    square(90, 4, 2000, 1);
    square(50, 4, 2000, 1);
    check(n_val - base >= 18, "R6", "per-beat reports", n_val - base, 18);

    // R8: sparse sample strobes
    base = n_val;
    square(60, 5, 2000, 3);
    check(n_val - base >= 8, "R8", "reports with gaps", n_val - base, 8);

    // R7: silence longer than the limit, then resume: timeout then valid
    for (int i = 0; i < 450; i++) step(1'b1, 0);
    base = n_tmo;
    square(60, 4, 2000, 1);
    check(n_tmo - base == 2, "R7", "timeouts after silence", n_tmo - base, 2);

    // R3: threshold above the filtered swing gives no edges
    hyst_thr = DW'(30000);
    base = n_ev;
    square(60, 4, 1000, 1);
    check(n_ev == base, "R3", "no event above threshold", n_ev - base, 0);

    // R3: lowering it again resumes reports
    hyst_thr = DW'(100);
    base = n_val;
    square(60, 4, 1000, 1);
    check(n_val - base >= 4, "R3", "events after lowering threshold", n_val - base, 4);

    // R1/R4: reset again mid-stream, first edges must re-arm silently
    @(negedge clk);
    compare();
    rst_n = 1'b0; smp_valid = 1'b0; in_reset = 1'b1;
    m_dc = 0; m_lp = 0; m_hi = 0;
    m_cnt = '{0, 0}; m_arm = '{0, 0};
    e_v = 0; e_r = 0; e_t = 0; e_len = 0;
    repeat (3) begin
      @(negedge clk);
      compare();
    end
    rst_n = 1'b1; in_reset = 1'b0;
    square(60, 3, 2000, 1);
    for (int i = 0; i < 4; i++) step(1'b0, 0);

    summary();
    $finish;
  end
endmodule